// File: doc/BRIEF.md
# Segmented Trigger Capture Address Generator

This block produces the write side of a capture memory that holds several trigger windows. At arm time the memory is split into a power-of-two number of equal segments. The write pointer runs around the active segment while the block waits for a trigger. When a trigger arrives, the block writes a programmed number of post-trigger samples and then moves to the next segment. When the last segment has taken its post-trigger samples, the done flag is raised. A sample is taken on every cycle in which the sample strobe is high. The capture memory itself and the trigger logic sit outside this block.

For each segment the address of the sample that carried the trigger is stored in a small register file. Software or a readout engine reads this file through an index port, so it can find where each window's trigger sits once capture has ended. Arming again clears the record and the done flag and restarts at segment 0.

Top module: `seg_capture`

## Requirements
- R1: After reset the block is idle. `wr_en`, `done` and `rd_valid` are 0 and `cur_seg` is 0, and strobes or triggers do not cause writes until the block is armed.
- R2: An `arm` pulse latches the segment count as 2^`seg_log2` and the segment length as 2^(ADDR_W−`seg_log2`). It latches the post-trigger count as `post_len` modulo the segment length. `arm` has priority over every other input in that cycle.
- R3: Each write goes to address `cur_seg` × segment length + offset, so the segment index sits in the upper `seg_log2` address bits.
- R4: While the block is acquiring, `wr_en` equals `sample_valid`. Before a trigger, the offset advances by one per strobed sample and wraps to 0 at the end of the segment.
- R5: A trigger counts only in the pre-trigger phase and only with `sample_valid` high. The address of that triggering sample is stored as the record entry for the current segment.
- R6: After a trigger, exactly the latched post-trigger count of further strobed samples is written, and the last of them closes the segment. With a count of 0, the triggering sample closes the segment. The next segment starts at offset 0.
- R7: A trigger during the post-trigger fill is ignored. It changes neither the record nor the point at which the segment closes.
- R8: `done` rises in the cycle after the sample that closes the last segment. While `done` is high, no writes occur, and `done` stays high until the next `arm`.
- R9: `rd_addr` and `rd_valid` show the record entry selected by `rd_idx` in the same cycle. An entry is valid only once its segment has triggered since the last arm.
- R10: An `arm` in the middle of an acquisition restarts capture at segment 0 with the new settings, and clears all record entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start or restart an acquisition |
| seg_log2 | input | LOG_W | Base-2 log of the segment count, latched on arm |
| post_len | input | ADDR_W | Post-trigger sample count, latched on arm |
| sample_valid | input | 1 | A sample is present this cycle |
| trig | input | 1 | Trigger event from external trigger logic |
| rd_idx | input | MAX_SEG_LOG2 | Record entry to read |
| wr_en | output | 1 | Write strobe to the capture memory |
| wr_addr | output | ADDR_W | Capture memory write address |
| cur_seg | output | MAX_SEG_LOG2 | Segment currently being filled |
| done | output | 1 | All segments are filled |
| rd_addr | output | ADDR_W | Trigger address stored for the selected segment |
| rd_valid | output | 1 | Selected entry holds a trigger address |

## Verification
`wr_en`, `wr_addr`, `rd_addr` and `rd_valid` are combinational from registered state and the present inputs, so they are due in the same cycle as the strobe or index that drives them. The offset advance, the segment step, the record write and `done` all appear one clock after the edge that samples the closing or triggering input. The bench applies inputs on the falling edge and compares every output 1 ns later against a behavioural model. That model changes its own state only after the comparison, so each expectation lines up with the edge at which the design's registers change.

// File: rtl/seg_capture_pkg.sv
package seg_capture_pkg;

    localparam int unsigned SC_ADDR_W       = 8;
    localparam int unsigned SC_MAX_SEG_LOG2 = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } cap_state_e;

    // saturate a requested segment exponent to the supported maximum
    function automatic int unsigned clamp_lg(input int unsigned req, input int unsigned maxv);
        return (req > maxv) ? maxv : req;
    endfunction

endpackage

// File: rtl/seg_capture_ctrl.sv
module seg_capture_ctrl
    import seg_capture_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int MAX_SEG_LOG2 = 3,
    parameter int LOG_W        = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    arm,
    input  logic [LOG_W-1:0]        seg_log2,
    input  logic [ADDR_W-1:0]       post_len,
    input  logic                    sample_valid,
    input  logic                    trig,
    output cap_state_e              state_o,
    output logic [MAX_SEG_LOG2-1:0] seg_o,
    output logic [ADDR_W-1:0]       off_o,
    output logic [LOG_W-1:0]        lg_o,
    output logic                    wr_en_o,
    output logic                    rec_we_o
);

    cap_state_e              state;
    logic [MAX_SEG_LOG2-1:0] seg;
    logic [ADDR_W-1:0]       off;
    logic [ADDR_W-1:0]       rem;
    logic [ADDR_W-1:0]       plen;
    logic [LOG_W-1:0]        lg;

    logic [ADDR_W-1:0]       mask;
    logic [ADDR_W-1:0]       off_inc;
    logic [MAX_SEG_LOG2-1:0] last_seg;
    logic [LOG_W-1:0]        arm_lg;
    logic [ADDR_W-1:0]       arm_mask;
    logic                    take_trig;
    logic                    seg_end;

    always_comb begin
        mask     = {ADDR_W{1'b1}} >> lg;
        off_inc  = (off + ADDR_W'(1)) & mask;
        last_seg = {MAX_SEG_LOG2{1'b1}} >> (MAX_SEG_LOG2 - int'(lg));
        arm_lg   = LOG_W'(clamp_lg(int'(seg_log2), MAX_SEG_LOG2));
        arm_mask = {ADDR_W{1'b1}} >> arm_lg;
        wr_en_o  = sample_valid && ((state == ST_PRE) || (state == ST_POST));
        take_trig = (state == ST_PRE) && sample_valid && trig;
        rec_we_o = take_trig;
        seg_end  = (take_trig && (plen == '0)) ||
                   ((state == ST_POST) && sample_valid && (rem == ADDR_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            seg   <= '0;
            off   <= '0;
            rem   <= '0;
            plen  <= '0;
            lg    <= '0;
        end else if (arm) begin
            state <= ST_PRE;
            seg   <= '0;
            off   <= '0;
            rem   <= '0;
            lg    <= arm_lg;
            plen  <= post_len & arm_mask;
        end else begin
            if (wr_en_o)
                off <= off_inc;
            if (take_trig && (plen != '0)) begin
                state <= ST_POST;
                rem   <= plen;
            end
            if ((state == ST_POST) && sample_valid)
                rem <= rem - ADDR_W'(1);
            if (seg_end) begin
                if (seg == last_seg) begin
                    state <= ST_DONE;
                end else begin
                    seg   <= seg + MAX_SEG_LOG2'(1);
                    off   <= '0;
                    state <= ST_PRE;
                end
            end
        end
    end

    assign state_o = state;
    assign seg_o   = seg;
    assign off_o   = off;
    assign lg_o    = lg;

endmodule

// File: rtl/seg_capture_addr.sv
module seg_capture_addr #(
    parameter int ADDR_W       = 8,
    parameter int MAX_SEG_LOG2 = 3,
    parameter int LOG_W        = 2
) (
    input  logic [MAX_SEG_LOG2-1:0] seg,
    input  logic [ADDR_W-1:0]       off,
    input  logic [LOG_W-1:0]        lg,
    output logic [ADDR_W-1:0]       addr
);

    // segment index occupies the top lg bits of the address
    always_comb begin
        addr = (ADDR_W'(seg) << (ADDR_W - int'(lg))) | off;
    end

endmodule

// File: rtl/seg_capture_trigrec.sv
module seg_capture_trigrec #(
    parameter int ADDR_W       = 8,
    parameter int MAX_SEG_LOG2 = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    we,
    input  logic [MAX_SEG_LOG2-1:0] wseg,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [MAX_SEG_LOG2-1:0] rd_idx,
    output logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_valid
);

    localparam int NSEG = 1 << MAX_SEG_LOG2;

    logic [ADDR_W-1:0] ent [NSEG];
    logic [NSEG-1:0]   vld;

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                vld[g] <= 1'b0;
                ent[g] <= '0;
            end else if (we && (wseg == MAX_SEG_LOG2'(g))) begin
                vld[g] <= 1'b1;
                ent[g] <= waddr;
            end
        end
    end

    assign rd_addr  = ent[rd_idx];
    assign rd_valid = vld[rd_idx];

endmodule

// File: rtl/seg_capture.sv
module seg_capture
    import seg_capture_pkg::*;
#(
    parameter int ADDR_W       = SC_ADDR_W,
    parameter int MAX_SEG_LOG2 = SC_MAX_SEG_LOG2,
    localparam int LOG_W       = $clog2(MAX_SEG_LOG2 + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    arm,
    input  logic [LOG_W-1:0]        seg_log2,
    input  logic [ADDR_W-1:0]       post_len,
    input  logic                    sample_valid,
    input  logic                    trig,
    input  logic [MAX_SEG_LOG2-1:0] rd_idx,
    output logic                    wr_en,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [MAX_SEG_LOG2-1:0] cur_seg,
    output logic                    done,
    output logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_valid
);

    cap_state_e        st;
    logic [ADDR_W-1:0] off;
    logic [LOG_W-1:0]  lg;
    logic              rec_we;

    seg_capture_ctrl #(
        .ADDR_W(ADDR_W), .MAX_SEG_LOG2(MAX_SEG_LOG2), .LOG_W(LOG_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .arm(arm), .seg_log2(seg_log2),
        .post_len(post_len), .sample_valid(sample_valid), .trig(trig),
        .state_o(st), .seg_o(cur_seg), .off_o(off), .lg_o(lg),
        .wr_en_o(wr_en), .rec_we_o(rec_we)
    );

    seg_capture_addr #(
        .ADDR_W(ADDR_W), .MAX_SEG_LOG2(MAX_SEG_LOG2), .LOG_W(LOG_W)
    ) u_addr (
        .seg(cur_seg), .off(off), .lg(lg), .addr(wr_addr)
    );

    seg_capture_trigrec #(
        .ADDR_W(ADDR_W), .MAX_SEG_LOG2(MAX_SEG_LOG2)
    ) u_rec (
        .clk(clk), .rst(rst), .clr(arm), .we(rec_we), .wseg(cur_seg),
        .waddr(wr_addr), .rd_idx(rd_idx), .rd_addr(rd_addr), .rd_valid(rd_valid)
    );

    assign done = (st == ST_DONE);

endmodule

// File: rtl/seg_capture_chk.sv
module seg_capture_chk #(
    parameter int MAX_SEG_LOG2 = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    arm,
    input logic                    sample_valid,
    input logic                    wr_en,
    input logic                    done,
    input logic [MAX_SEG_LOG2-1:0] cur_seg
);

    // R4
    wr_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> sample_valid);

    // R8
    done_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !arm) |=> done);

    // R8
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(wr_en));

    // R10
    arm_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> !done);

    // R6
    seg_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_seg != $past(cur_seg)) |->
            ((cur_seg == $past(cur_seg) + MAX_SEG_LOG2'(1)) || (cur_seg == '0)));

endmodule

bind seg_capture seg_capture_chk #(.MAX_SEG_LOG2(MAX_SEG_LOG2)) u_chk (
    .clk(clk), .rst(rst), .arm(arm), .sample_valid(sample_valid),
    .wr_en(wr_en), .done(done), .cur_seg(cur_seg)
);

// File: tb/seg_capture_bench.sv
`timescale 1ns/1ps
module seg_capture_bench;

    localparam int AW = 8;
    localparam int ML = 3;
    localparam int NS = 1 << ML;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm = 1'b0;
    logic [1:0]    seg_log2 = '0;
    logic [AW-1:0] post_len = '0;
    logic          sample_valid = 1'b0;
    logic          trig = 1'b0;
    logic [ML-1:0] rd_idx = '0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [ML-1:0] cur_seg;
    logic          done;
    logic [AW-1:0] rd_addr;
    logic          rd_valid;

    seg_capture u_seg_capture (
        .clk(clk), .rst(rst), .arm(arm), .seg_log2(seg_log2), .post_len(post_len),
        .sample_valid(sample_valid), .trig(trig), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_addr(wr_addr), .cur_seg(cur_seg), .done(done),
        .rd_addr(rd_addr), .rd_valid(rd_valid)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    finished = 0;
    string req = "R1";

    // behavioural model: 0 idle, 1 waiting for trigger, 2 post fill, 3 complete
    int mst = 0, mseg = 0, moff = 0, mrem = 0, nseg = 1, slen = 256, plen = 0;
    int rec_a [NS];
    bit rec_v [NS];

    task automatic chk(input string fld, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, fld, act, exp);
        end
    endtask

    task automatic finish_seg();
        if (mseg == nseg - 1) mst = 3;
        else begin mseg++; moff = 0; mst = 1; end
    endtask

    task automatic step(input bit a, input int lg, input int pl, input bit sv, input bit tg);
        int ewe, eaddr, idx;
        @(negedge clk);
        arm = a; seg_log2 = 2'(lg); post_len = AW'(pl);
        sample_valid = sv; trig = tg; rd_idx = ML'(cyc % NS);
        idx = cyc % NS;
        cyc++;
        #1;
        ewe   = (sv && (mst == 1 || mst == 2)) ? 1 : 0;
        eaddr = mseg * slen + moff;
        chk("wr_en", int'(wr_en), ewe);
        if (ewe == 1) chk("wr_addr", int'(wr_addr), eaddr);
        chk("cur_seg", int'(cur_seg), mseg);
        chk("done", int'(done), (mst == 3) ? 1 : 0);
        chk("rd_valid", int'(rd_valid), int'(rec_v[idx]));
        if (rec_v[idx]) chk("rd_addr", int'(rd_addr), rec_a[idx]);
        // advance the model to the state after the coming rising edge
        if (a) begin
            int l;
            l = (lg > ML) ? ML : lg;
            mst = 1; mseg = 0; moff = 0; mrem = 0;
            nseg = 1 << l; slen = 1 << (AW - l); plen = pl % slen;
            for (int k = 0; k < NS; k++) rec_v[k] = 0;
        end else if (mst == 1 && sv) begin
            moff = (moff + 1) % slen;
            if (tg) begin
                rec_a[mseg] = eaddr; rec_v[mseg] = 1;
                if (plen == 0) finish_seg();
                else begin mst = 2; mrem = plen; end
            end
        end else if (mst == 2 && sv) begin
            moff = (moff + 1) % slen;
            if (mrem == 1) finish_seg();
            else mrem--;
        end
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NS; k++) begin rec_v[k] = 0; rec_a[k] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: idle after reset, strobes and triggers write nothing
        req = "R1";
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, i[0]);

        // R3 R4 R5 R7 R8: four segments of 64, five post samples
        req = "R2";
        step(1, 2, 5, 0, 0);
        for (int s = 0; s < 4; s++) begin
            req = "R4";
            for (int i = 0; i < 70; i++) begin
                // i%4==3 carries no strobe; a trigger there must be ignored (R5)
                if (i == 3) req = "R5";
                if (i == 4) req = "R3";
                step(0, 0, 0, (i % 4) != 3, (i == 3) || (i == 69));
            end
            req = "R7";
            for (int j = 0; j < 7; j++) step(0, 0, 0, (j != 2) && (j != 4), 1);
        end
        req = "R8";
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 1);

        // R2: single segment, post count 300 taken modulo 256
        req = "R2";
        step(1, 0, 300, 0, 0);
        for (int i = 0; i < 20; i++) step(0, 0, 0, 1, i == 19);
        for (int i = 0; i < 50; i++) step(0, 0, 0, 1, 0);

        // R6: eight segments, zero post count
        req = "R6";
        step(1, 3, 0, 0, 0);
        for (int s = 0; s < 8; s++)
            for (int i = 0; i < 3; i++) step(0, 0, 0, 1, i == 2);
        req = "R9";
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0);

        // R10: re-arm in the middle of a post fill, arm wins over strobe and trigger
        req = "R10";
        step(1, 1, 3, 0, 0);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, i == 4);
        step(1, 2, 2, 1, 1);
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 6; i++) step(0, 0, 0, 1, i == 1);
        req = "R8";
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule